// File: doc/BRIEF.md
# Edge-Latched Address Static RAM

This block models a 1024-word by 4-bit static memory. It has an active-low chip enable, an active-low write enable and a 10-bit address. The shared data bus is split into an input bus, an output bus and an output-enable flag. A system clock samples both control pins, so the block finds control edges without using the pins as clocks. When the chip enable is seen going low, the address present on that clock edge goes into an internal register. That register then addresses the rest of the cycle, and the address pins may wander freely until the next falling edge.

Storage is a grid of 64 rows by 64 bits. The upper six address bits pick the row and the lower four bits pick one of sixteen 4-bit groups in that row. A read drives the output bus while the chip is enabled and write enable is high. A write opens while both controls are low. It commits the input bus at the clock edge where the first of the two controls is seen high again. Write enable may stay low across several enable pulses to fill a series of locations. If write enable rises first, the outputs turn back on and show the word just stored.

Top module: `la_sram`

## Requirements
- R1: Every one of the 1024 addresses holds its own 4-bit word: a word written there is read back unchanged.
- R2: The address is captured at the first clock edge on which `ce_n` is sampled low after being sampled high. Changes on `addr` after that edge do not affect the read or write in progress.
- R3: `addr[9:4]` selects the row and `addr[3:0]` selects the 4-bit group within it. A write to one address leaves every address that differs in a single bit unchanged.
- R4: At a clock edge where `ce_n` is sampled high, nothing is captured or written, and `dq_oe` is 0 after that edge, whatever `we_n`, `addr` and `dq_in` do.
- R5: At a clock edge where `ce_n` is sampled low and `we_n` high, `dq_oe` becomes 1. `dq_out` then shows the stored word at the latched address after that edge.
- R6: At a clock edge where `we_n` is sampled low, `dq_oe` becomes 0.
- R7: A write window is open after an edge that sampled both controls low. At the next edge where `ce_n` or `we_n` is sampled high, `dq_in` is stored at the latched address.
- R8: With `we_n` held low across several chip-enable pulses, each pulse writes its own latched address.
- R9: If `we_n` rises while `ce_n` stays low, the write commits and `dq_oe` returns to 1. From the second edge after the commit, `dq_out` shows the new word.
- R10: Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R11: While reset is held, `dq_oe` and `dq_out` are 0. Reset is asynchronous active-low and is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the control pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip enable; its falling edge latches the address |
| we_n | input | 1 | Active-low write enable; low turns the outputs off |
| addr | input | 10 | Word address: row in bits 9:4, group in bits 3:0 |
| dq_in | input | 4 | Write data from the shared bus |
| dq_out | output | 4 | Read data toward the shared bus, zero when not driven |
| dq_oe | output | 1 | High when the block drives the shared bus |

## Verification
On every cycle, the assertions check how the output-enable flag follows the sampled controls, that `dq_out` is zero while the bus is released, and that the latched address loads on a falling enable and holds for the rest of the cycle. Only the bench scenarios can show that stored words are correct. These scenarios are the full-capacity sweep, single-bit neighbour isolation, writes ignored while disabled, back-to-back writes with `we_n` held low, and the write that ends on write enable and then reads its own data back.

// File: rtl/la_sram_pkg.sv
package la_sram_pkg;
  localparam int unsigned DEF_ADDR_W = 10;
  localparam int unsigned DEF_DATA_W = 4;
  localparam int unsigned DEF_COL_W  = 4;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/la_sram_onehot.sv
module la_sram_onehot #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0]       idx,
  output logic [(1<<IDX_W)-1:0]  sel
);
  localparam int unsigned N = 1 << IDX_W;

  for (genvar i = 0; i < N; i++) begin : g_dec
    assign sel[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/la_sram_addr_latch.sv
module la_sram_addr_latch #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d  = addr_q;
    if (capture) addr_d = addr_in;
    rd_addr = addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/la_sram_array.sv
module la_sram_array #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned DATA_W = 4
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [(1<<ROW_W)-1:0] wr_row_sel,
  input  logic [(1<<COL_W)-1:0] wr_col_sel,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [ROW_W-1:0]      rd_row,
  input  logic [COL_W-1:0]      rd_col,
  output logic [DATA_W-1:0]     rd_word
);
  localparam int unsigned ROWS = 1 << ROW_W;
  localparam int unsigned COLS = 1 << COL_W;

  logic [ROWS-1:0][COLS-1:0][DATA_W-1:0] cells;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DATA_W-1:0] cell_q;
      logic              cell_we;
      assign cell_we = wr_en & wr_row_sel[r] & wr_col_sel[c];
      always_ff @(posedge clk) begin
        if (cell_we) cell_q <= wdata;
      end
      assign cells[r][c] = cell_q;
    end
  end

  assign rd_word = cells[rd_row][rd_col];
endmodule

// File: rtl/la_sram_ctrl.sv
module la_sram_ctrl
  import la_sram_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] rd_word,
  output logic              addr_capture,
  output logic              wr_commit,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);
  phase_e            phase_q, phase_d;
  logic              oe_d;
  logic [DATA_W-1:0] dout_d;

  always_comb begin
    addr_capture = (phase_q == PH_IDLE) && !ce_n;
    wr_commit    = (phase_q == PH_WRITE) && (ce_n || we_n);
    if (ce_n)      phase_d = PH_IDLE;
    else if (we_n) phase_d = PH_READ;
    else           phase_d = PH_WRITE;
    oe_d   = !ce_n && we_n;
    dout_d = oe_d ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
    end else begin
      phase_q <= phase_d;
      dq_oe   <= oe_d;
      dq_out  <= dout_d;
    end
  end
endmodule

// File: rtl/la_sram.sv
module la_sram
  import la_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned COL_W  = DEF_COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int unsigned ROW_W = ADDR_W - COL_W;
  localparam int unsigned ROWS  = 1 << ROW_W;
  localparam int unsigned COLS  = 1 << COL_W;

  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              addr_capture, wr_commit;
  logic [ADDR_W-1:0] lat_addr, rd_addr;
  logic [ROWS-1:0]   wr_row_sel;
  logic [COLS-1:0]   wr_col_sel;
  logic [DATA_W-1:0] rd_word;

  la_sram_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (addr_capture),
    .addr_in (addr),
    .addr_q  (lat_addr),
    .rd_addr (rd_addr)
  );

  la_sram_onehot #(.IDX_W(ROW_W)) u_row_dec (
    .idx (lat_addr[ADDR_W-1:COL_W]),
    .sel (wr_row_sel)
  );

  la_sram_onehot #(.IDX_W(COL_W)) u_col_dec (
    .idx (lat_addr[COL_W-1:0]),
    .sel (wr_col_sel)
  );

  la_sram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
    .clk        (clk),
    .wr_en      (wr_commit),
    .wr_row_sel (wr_row_sel),
    .wr_col_sel (wr_col_sel),
    .wdata      (dq_in),
    .rd_row     (rd_addr[ADDR_W-1:COL_W]),
    .rd_col     (rd_addr[COL_W-1:0]),
    .rd_word    (rd_word)
  );

  la_sram_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ce_n         (ce_n),
    .we_n         (we_n),
    .rd_word      (rd_word),
    .addr_capture (addr_capture),
    .wr_commit    (wr_commit),
    .dq_oe        (dq_oe),
    .dq_out       (dq_out)
  );
endmodule

// File: rtl/la_sram_chk.sv
module la_sram_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] addr_lat,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out
);
  logic prev_ce_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ce_n_q <= 1'b1;
    else        prev_ce_n_q <= ce_n;
  end

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_oe); // R4
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dq_oe); // R6
  AST_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && we_n) |=> dq_oe); // R5
  AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ce_n_q && !ce_n) |=> (addr_lat == $past(addr))); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_ce_n_q && !ce_n) |=> $stable(addr_lat)); // R2
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0)); // R10
endmodule

bind la_sram la_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .addr     (addr),
  .addr_lat (lat_addr),
  .dq_oe    (dq_oe),
  .dq_out   (dq_out)
);

// File: tb/la_sram_tb.sv
module la_sram_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ce_n, we_n;
  logic [9:0] addr;
  logic [3:0] dq_in, dq_out;
  logic       dq_oe;

  logic [3:0] ref_mem [1024];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  la_sram u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [3:0] pattern(input logic [9:0] a);
    return a[3:0] ^ a[9:6] ^ {a[5:4], a[5:4]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write with we_n falling before ce_n; ce_n rising ends the window.
  task automatic wr_ce_end(input logic [9:0] a, input logic [3:0] d, input bit keep_we);
    we_n = 1'b0; addr = a;
    @(negedge clk);
    ce_n = 1'b0;
    @(negedge clk);
    addr = 10'($urandom); dq_in = d; ce_n = 1'b1;
    @(negedge clk);
    if (!keep_we) we_n = 1'b1;
    dq_in = 4'($urandom);
    ref_mem[a] = d;
  endtask

  // Write with ce_n falling first; we_n rising ends the window (R9).
  task automatic wr_we_end(input logic [9:0] a, input logic [3:0] d);
    we_n = 1'b1; addr = a; ce_n = 1'b0;
    @(negedge clk);
    we_n = 1'b0; addr = 10'($urandom);
    @(negedge clk);
    chk(dq_oe === 1'b0, "R6", int'(dq_oe), 0);
    dq_in = d; we_n = 1'b1;
    @(negedge clk);
    dq_in = 4'($urandom);
    @(negedge clk);
    ref_mem[a] = d;
    chk(dq_oe === 1'b1, "R9", int'(dq_oe), 1);
    chk(dq_out === d, "R9", int'(dq_out), int'(d));
    ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [9:0] a, input string req);
    we_n = 1'b1; addr = a; ce_n = 1'b0;
    @(negedge clk);
    chk(dq_oe === 1'b1, "R5", int'(dq_oe), 1);
    chk(dq_out === ref_mem[a], req, int'(dq_out), int'(ref_mem[a]));
    addr = ~a;
    @(negedge clk);
    chk(dq_out === ref_mem[a], "R2", int'(dq_out), int'(ref_mem[a]));
    ce_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0 && dq_out === 4'h0, "R10", int'({dq_oe, dq_out}), 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      report();
      $finish;
    end
  end

  initial begin
    logic [9:0] base;
    logic [3:0] keep;
    void'($urandom(32'd20240611));
    rst_n = 1'b1; ce_n = 1'b1; we_n = 1'b1; addr = '0; dq_in = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dq_oe === 1'b0, "R11", int'(dq_oe), 0);
    chk(dq_out === 4'h0, "R11", int'(dq_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: full-capacity sweep
    for (int a = 0; a < 1024; a++) wr_ce_end(10'(a), pattern(10'(a)), 1'b0);
    for (int a = 0; a < 1024; a++) rd(10'(a), "R1");

    // R3: single-bit neighbours stay independent
    base = 10'h2A5;
    for (int b = 0; b < 10; b++) wr_ce_end(base ^ (10'd1 << b), 4'(b) ^ 4'hA, 1'b0);
    wr_ce_end(base, 4'h5, 1'b0);
    for (int b = 0; b < 10; b++) rd(base ^ (10'd1 << b), "R3");
    rd(base, "R3");

    // R4: disabled chip ignores write enable, address and data
    keep = ref_mem[10'h133];
    we_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      addr = (i % 2 == 0) ? 10'h133 : 10'($urandom);
      dq_in = ~keep;
      @(negedge clk);
      chk(dq_oe === 1'b0, "R4", int'(dq_oe), 0);
    end
    we_n = 1'b1;
    @(negedge clk);
    rd(10'h133, "R4");

    // R8: write enable held low across consecutive enable pulses
    for (int i = 0; i < 4; i++) wr_ce_end(10'h3F0 + 10'(i), 4'(i) + 4'h9, 1'b1);
    we_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd(10'h3F0 + 10'(i), "R8");

    // R9 / R7 directed corner: write ended by we_n at the top address
    wr_we_end(10'h3FF, 4'h6);
    rd(10'h3FF, "R7");

    // Constrained random mix
    for (int i = 0; i < 600; i++) begin
      logic [9:0] ra;
      logic [3:0] rdat;
      int unsigned sel;
      ra = 10'($urandom); rdat = 4'($urandom); sel = $urandom % 4;
      case (sel)
        0: wr_ce_end(ra, rdat, 1'b0);
        1: wr_we_end(ra, rdat);
        default: rd(ra, "R7");
      endcase
    end

    done = 1;
    report();
    $finish;
  end
endmodule